// File: doc/BRIEF.md
# Three-Wire Serial Tuning Control Receiver

This block takes frames from a three-wire serial link (data, serial clock, enable) and splits them into three held control fields. The fields are a four-bit band-switch word, a 15-bit divider ratio for a synthesizer loop, and a seven-bit word of test and feature controls. A faster system clock samples all three serial lines. Each line passes through a synchronizer, and an edge detector follows.

A frame opens when enable goes high. From then on, every rising serial-clock edge shifts in one data bit and advances a pulse counter, which stops at 35. The first bit sent is the top band bit, and every field is sent most significant bit first. Each field is copied to its holding register at a fixed pulse number:

- the band word on the falling serial-clock edge of pulse 4;
- the full ratio on the falling edge of pulse 19;
- the test word on the falling edge of pulse 34.

A short 18-bit frame carries only the lower 14 ratio bits. It commits on the enable fall, and the top ratio bit is cleared. Frames that end early keep whatever was already committed. Bits past pulse 34 have no effect.

Top module: `tune_ctl_rx`

## Requirements
- R1: After reset, band_out is 0, ratio_out is 256, test_out is 0 and ref_div_1024 is 0 (divide by 512).
- R2: On the falling serial-clock edge of pulse 4, band_out takes bits 1..4, with bit 1 in band_out[3].
- R3: On the falling edge of pulse 19, ratio_out takes bits 5..19, with bit 5 in ratio_out[14].
- R4: If enable falls after exactly 18 pulses, ratio_out becomes {0, bits 5..18}, with bit 5 in ratio_out[13].
- R5: A frame that ends after 4 to 17 pulses changes band_out only.
- R6: A frame that ends before pulse 4 changes no output.
- R7: On the falling edge of pulse 34, test_out takes bits 20..26, with bit 20 in test_out[6]. Bits 27..34 are ignored.
- R8: Pulses 35 and later in a frame have no effect on any output.
- R9: A frame shorter than 34 pulses leaves test_out unchanged. ref_div_1024 always equals test_out[5], where 1 selects divide by 1024.
- R10: Serial-clock pulses while enable is low have no effect, and the next frame counts from pulse 1.
- R11: Each ratio commit (pulse 19, or the 18-pulse enable fall) gives exactly one single-cycle ratio_load pulse. ratio_out changes only in a cycle with ratio_load high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low power-on reset |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data, sampled on the rising serial-clock edge |
| ser_en | input | 1 | Frame enable, high during a frame |
| band_out | output | 4 | Held band-switch word |
| ratio_out | output | 15 | Held divider ratio |
| ratio_load | output | 1 | One-cycle strobe when ratio_out is committed |
| test_out | output | 7 | Held test and feature word |
| ref_div_1024 | output | 1 | Reference divide select (1 = 1024, 0 = 512) |

## Verification
On every cycle, the assertions check these properties:

- the pulse counter never passes its limit;
- the counter clears while enable is low;
- the shift register is frozen once the counter has saturated;
- at most one commit fires per cycle;
- the ratio changes only together with its load strobe.

Some behaviour can only be shown by the bench scenarios, which compare the held fields with expected values. These are the field positions and bit order, the clearing of the top ratio bit in 18-pulse frames, and what each frame length leaves committed. The bench sweeps every frame length from 0 to 40 pulses, each starting from a known committed state.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
   typedef struct packed {
      logic band;
      logic ratio_full;
      logic ratio_short;
      logic test;
   } tcr_commit_t;
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tcr_sync: STAGES must be at least 2");
      end
      for (genvar gi = 0; gi < W; gi++) begin : g_line
         logic [STAGES-1:0] chain_q;
         logic              prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
               prev_q  <= 1'b0;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d[gi]};
               prev_q  <= chain_q[STAGES-1];
            end
         end
         assign lvl[gi]  = chain_q[STAGES-1];
         assign rise[gi] = chain_q[STAGES-1] & ~prev_q;
         assign fall[gi] = ~chain_q[STAGES-1] & prev_q;
      end
   endgenerate
endmodule

// File: rtl/tcr_frame.sv
module tcr_frame
   import tcr_pkg::*;
#(
   parameter int BAND_W  = 4,
   parameter int RATIO_W = 15,
   parameter int TEST_W  = 7,
   parameter int PAD_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_rise,
   input  logic               clk_fall,
   input  logic               en_lvl,
   input  logic               en_fall,
   input  logic               dat,
   output logic [RATIO_W-1:0] shift_q,
   output tcr_commit_t        commit
);
   localparam int BAND_END  = BAND_W;
   localparam int RATIO_END = BAND_W + RATIO_W;
   localparam int TEST_END  = RATIO_END + TEST_W + PAD_W;
   localparam int SAT       = TEST_END + 1;
   localparam int CNT_W     = $clog2(SAT + 1);

   generate
      if (RATIO_W < TEST_W + PAD_W || RATIO_W < BAND_W) begin : g_bad_widths
         $error("tcr_frame: shift register narrower than a field window");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         shift_q <= '0;
      end else if (!en_lvl) begin
         cnt_q <= '0;
      end else if (clk_rise) begin
         if (cnt_q != CNT_W'(SAT)) cnt_q <= cnt_q + 1'b1;
         if (cnt_q < CNT_W'(TEST_END)) shift_q <= {shift_q[RATIO_W-2:0], dat};
      end
   end

   always_comb begin
      commit.band        = en_lvl & clk_fall & (cnt_q == CNT_W'(BAND_END));
      commit.ratio_full  = en_lvl & clk_fall & (cnt_q == CNT_W'(RATIO_END));
      commit.test        = en_lvl & clk_fall & (cnt_q == CNT_W'(TEST_END));
      commit.ratio_short = en_fall & (cnt_q == CNT_W'(RATIO_END - 1));
   end

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(SAT));
   // R8
   shift_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(SAT)) |=> $stable(shift_q));
   // R10
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_lvl |=> (cnt_q == '0));
   // R5
   commit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(commit));
endmodule

// File: rtl/tcr_regs.sv
module tcr_regs
   import tcr_pkg::*;
#(
   parameter int BAND_W    = 4,
   parameter int RATIO_W   = 15,
   parameter int TEST_W    = 7,
   parameter int PAD_W     = 8,
   parameter int POR_RATIO = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] shift_q,
   input  tcr_commit_t        commit,
   output logic [BAND_W-1:0]  band_q,
   output logic [RATIO_W-1:0] ratio_q,
   output logic               ratio_load_q,
   output logic [TEST_W-1:0]  test_q
);
   localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(POR_RATIO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         band_q       <= '0;
         ratio_q      <= RATIO_RST;
         ratio_load_q <= 1'b0;
      end else begin
         ratio_load_q <= commit.ratio_full | commit.ratio_short;
         if (commit.band) band_q <= shift_q[BAND_W-1:0];
         if (commit.ratio_full) ratio_q <= shift_q;
         else if (commit.ratio_short) ratio_q <= {1'b0, shift_q[RATIO_W-2:0]};
      end
   end

   generate
      for (genvar gt = 0; gt < TEST_W; gt++) begin : g_test
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) test_q[gt] <= 1'b0;
            else if (commit.test) test_q[gt] <= shift_q[PAD_W + gt];
         end
      end
   endgenerate

   // R11
   ratio_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ratio_q) |-> ratio_load_q);
   // R11
   load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_load_q |=> !ratio_load_q);
endmodule

// File: rtl/tune_ctl_rx.sv
module tune_ctl_rx
   import tcr_pkg::*;
#(
   parameter int BAND_W      = 4,
   parameter int RATIO_W     = 15,
   parameter int TEST_W      = 7,
   parameter int PAD_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int POR_RATIO   = 256,
   parameter int REF_SEL_BIT = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_dat,
   input  logic               ser_en,
   output logic [BAND_W-1:0]  band_out,
   output logic [RATIO_W-1:0] ratio_out,
   output logic               ratio_load,
   output logic [TEST_W-1:0]  test_out,
   output logic               ref_div_1024
);
   generate
      if (REF_SEL_BIT >= TEST_W) begin : g_bad_ref
         $error("tune_ctl_rx: REF_SEL_BIT outside the test word");
      end
   endgenerate

   logic [2:0]         s_lvl, s_rise, s_fall;
   logic [RATIO_W-1:0] shift_q;
   tcr_commit_t        commit;

   tcr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ser_en, ser_dat, ser_clk}),
      .lvl(s_lvl), .rise(s_rise), .fall(s_fall));

   tcr_frame #(.BAND_W(BAND_W), .RATIO_W(RATIO_W), .TEST_W(TEST_W), .PAD_W(PAD_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .clk_rise(s_rise[0]), .clk_fall(s_fall[0]),
      .en_lvl(s_lvl[2]), .en_fall(s_fall[2]), .dat(s_lvl[1]),
      .shift_q(shift_q), .commit(commit));

   tcr_regs #(.BAND_W(BAND_W), .RATIO_W(RATIO_W), .TEST_W(TEST_W), .PAD_W(PAD_W),
              .POR_RATIO(POR_RATIO)) u_regs (
      .clk(clk), .rst_n(rst_n), .shift_q(shift_q), .commit(commit),
      .band_q(band_out), .ratio_q(ratio_out), .ratio_load_q(ratio_load), .test_q(test_out));

   assign ref_div_1024 = test_out[REF_SEL_BIT];
endmodule

// File: tb/tb_tune_ctl_rx.sv
module tb_tune_ctl_rx;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
   logic [3:0]  band_out;
   logic [14:0] ratio_out;
   logic        ratio_load;
   logic [6:0]  test_out;
   logic        ref_div_1024;
   int compared = 0, mismatched = 0, loads = 0;
   bit done = 0;
   localparam int HP = 3;

   always #2 clk = ~clk;

   tune_ctl_rx dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_en(ser_en), .band_out(band_out), .ratio_out(ratio_out), .ratio_load(ratio_load),
      .test_out(test_out), .ref_div_1024(ref_div_1024));

   always @(negedge clk) if (rst_n && ratio_load) loads++;

   task automatic check(string req, int got, int exp);
      compared++;
      if (got != exp) begin
         mismatched++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic waitc(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic bit_at(int p, int n, logic [3:0] b, logic [14:0] r, logic [6:0] t);
      if (p <= 4) return b[4-p];
      if (n == 18) return r[18-p];
      if (p <= 19) return r[19-p];
      if (p <= 26) return t[26-p];
      return p[0];
   endfunction

   task automatic pulse(logic d);
      ser_dat = d; waitc(HP);
      ser_clk = 1'b1; waitc(HP);
      ser_clk = 1'b0; waitc(HP);
   endtask

   task automatic send(int n, logic [3:0] b, logic [14:0] r, logic [6:0] t);
      ser_en = 1'b1; waitc(HP);
      for (int p = 1; p <= n; p++) pulse(bit_at(p, n, b, r, t));
      ser_en = 1'b0; waitc(10);
   endtask

   task automatic check_all(string req, int eb, int er, int et);
      check({req, " band"}, band_out, eb);
      check({req, " ratio"}, ratio_out, er);
      check({req, " test"}, test_out, et);
      check("R9 ref", ref_div_1024, et >> 5 & 1);
   endtask

   initial begin
      waitc(5); rst_n = 1'b1; waitc(5);
      // R1 reset defaults
      check_all("R1", 0, 256, 0);
      check("R1 load", loads, 0);

      // R10 pulses with enable low change nothing
      for (int k = 0; k < 25; k++) pulse(k[0]);
      waitc(10);
      check_all("R10", 0, 256, 0);
      send(19, 4'h9, 15'h5A5A, 7'h0);
      check_all("R10 next frame R3", 9, 15'h5A5A, 0);
      check("R11 one load", loads, 1);

      // sweep every frame length from 0 to 40
      for (int n = 0; n <= 40; n++) begin
         logic [3:0] nb;
         logic [14:0] nr;
         logic [6:0] nt;
         int eb, er, et, l0;
         nb = 4'h5 ^ n[3:0];
         nr = 15'h7ABC ^ 15'(n * 37);
         nt = 7'h2A ^ 7'(n * 5);
         send(34, 4'hA, 15'h1234, 7'h55);
         check_all("R7 base", 4'hA, 15'h1234, 7'h55);
         l0 = loads;
         send(n, nb, nr, nt);
         eb = (n >= 4) ? nb : 4'hA;
         er = (n >= 19) ? nr : (n == 18) ? {1'b0, nr[13:0]} : 15'h1234;
         et = (n >= 34) ? nt : 7'h55;
         if (n < 4) check_all("R6", eb, er, et);
         else if (n < 18) check_all("R5", eb, er, et);
         else if (n == 18) check_all("R4", eb, er, et);
         else if (n < 34) check_all("R9", eb, er, et);
         else if (n == 34) check_all("R7", eb, er, et);
         else check_all("R8", eb, er, et);
         check("R11 load count", loads - l0, (n >= 18) ? 1 : 0);
      end

      // R2 band bit order explicit
      send(4, 4'b1000, 15'h0, 7'h0);
      check("R2 first bit to band[3]", band_out, 8);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         compared++; mismatched++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule